// File: doc/BRIEF.md
# Dual-mode parallel display bus writer

This block turns write requests from on-chip logic into bus cycles on the parallel host port of a display controller. Each request carries a type and a byte. An index write drives register select low. A parameter write and a pixel-component write drive it high. A controller command is therefore sent as an index request followed by a parameter request. The requester hands over each request with a valid/ready handshake. Ready stays low until the bus cycle has ended.

A static mode input selects the signalling style. In strobe mode (8080 style), both the read pin and the write pin are active low, and the write pin pulses. In enable mode (6800 style), the read pin becomes an active-high enable, and the write pin becomes a read/write select in which low means write. Every bus cycle has three phases, and the length of each phase is set from configuration inputs:

- a setup phase, with chip select low and data and register select driven;
- a strobe phase;
- a hold phase, in which the strobe is released while chip select stays low.

In 6-bit colour mode, a pixel-component byte is placed on the top six lines of the 18-line data bus, and all lower lines are cleared. The requester sends one pixel as three component requests in red, green, blue order. The block also drives an active-low reset to the controller.

Top module: `pbus_writer`

## Requirements
- R1: While rstN is low, ctrlRstN is low, busCsN is high and reqReady is high. ctrlRstN goes high on the first clock edge after rstN is released.
- R2: Request type encoding is 0 = index, 1 = parameter, 2 = pixel component and 3 = reserved. During a bus cycle, busRs is 0 for an index and 1 for the other two types. Outside 6-bit colour pixels, the byte appears on busData[7:0] with bits 17..8 zero. A type-3 request is accepted and causes no bus cycle.
- R3: reqReady is high exactly when no bus cycle is in progress. A request is taken on a clock edge where reqValid and reqReady are both high. reqReady is then low for cfgSetup+cfgStrobe+cfgHold+3 cycles.
- R4: In strobe mode (modeSel=0), the phases run in this order after acceptance, with busCsN low throughout. Setup lasts cfgSetup+1 cycles with busWrPin high. The strobe lasts cfgStrobe+1 cycles with busWrPin low. Hold lasts cfgHold+1 cycles with busWrPin high. busRdPin stays high at all times.
- R5: In enable mode (modeSel=1), busRdPin is the enable and busWrPin is the read/write select. When idle, busRdPin is 0 and busWrPin is 1. During a bus cycle, busWrPin is 0, and busRdPin is 1 only in the strobe phase.
- R6: busData and busRs do not change at any point during a bus cycle.
- R7: With colorMode=1 at acceptance, a pixel request puts reqData[5:0] on busData[17:12] and drives busData[11:0] to zero. Index and parameter requests are unaffected by colorMode.
- R8: modeSel, colorMode and the three timing inputs are sampled when a request is accepted. Changing them during a bus cycle has no effect on that cycle. The idle pin levels follow modeSel one cycle later.
- R9: When idle, busCsN is 1, busRs is 0 and busData is zero.
- R10: The strobe is released at least one cycle before busCsN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0 = strobe signalling, 1 = enable signalling |
| colorMode | input | 1 | 1 = pixel components go on the top six data lines |
| cfgSetup | input | 4 | Setup phase length minus one |
| cfgStrobe | input | 4 | Strobe phase length minus one |
| cfgHold | input | 4 | Hold phase length minus one |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block can take a request |
| reqType | input | 2 | Request type (index, parameter, pixel, reserved) |
| reqData | input | 8 | Request byte |
| busCsN | output | 1 | Chip select, active low |
| busRs | output | 1 | Register select |
| busRdPin | output | 1 | Read strobe (strobe mode) or enable (enable mode) |
| busWrPin | output | 1 | Write strobe (strobe mode) or read/write select (enable mode) |
| busData | output | 18 | Data lines |
| ctrlRstN | output | 1 | Reset to the controller, active low |

## Verification
The assertions check the following on every cycle:

- data and register select hold steady through a bus cycle;
- the latched mode does not move while busy;
- every strobe is preceded by a setup cycle and ends while chip select is still low;
- ready drops after each accepted request;
- lower data lines are clear whenever a colour component is on the bus.

Only the bench scenarios can show the exact phase lengths for a given configuration and the pin levels in each mode. The same holds for the register-select value per request type, the dropping of reserved requests, and the immunity of a running cycle to mid-cycle changes of mode, colour mode and timing.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    REQ_INDEX = 2'd0,
    REQ_PARAM = 2'd1,
    REQ_PIXEL = 2'd2,
    REQ_RSVD  = 2'd3
  } req_e;

  typedef struct packed {
    logic load;
    logic busy;
    logic strobeOn;
    logic mode6800;
  } busCtl_t;
endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic             reqValid,
  input  logic [1:0]       reqType,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgStrobe,
  input  logic [CNT_W-1:0] cfgHold,
  output logic             reqReady,
  output busCtl_t          ctl
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] strobeLen;
  logic [CNT_W-1:0] holdLen;
  logic             modeReg;
  logic             start;
  logic             cntDone;

  assign reqReady = (phase == PH_IDLE);
  assign start    = reqValid && reqReady && (reqType != REQ_RSVD);
  assign cntDone  = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      strobeLen <= '0;
      holdLen   <= '0;
      modeReg   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          modeReg <= modeSel;
          if (start) begin
            phase     <= PH_SETUP;
            cnt       <= cfgSetup;
            strobeLen <= cfgStrobe;
            holdLen   <= cfgHold;
          end
        end
        PH_SETUP: begin
          if (cntDone) begin
            phase <= PH_STROBE;
            cnt   <= strobeLen;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cntDone) begin
            phase <= PH_HOLD;
            cnt   <= holdLen;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cntDone) phase <= PH_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ctl.load     = start;
    ctl.busy     = (phase != PH_IDLE);
    ctl.strobeOn = (phase == PH_STROBE);
    ctl.mode6800 = modeReg;
  end

  // R3: an accepted request takes ready away on the next cycle
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !reqReady);

  // R8: latched mode never moves inside a bus cycle
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && $past(ctl.busy)) |-> $stable(modeReg));

  // R4: a strobe is always preceded by at least one busy (setup) cycle
  p_setup_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.strobeOn) |-> $past(ctl.busy));

  // R10: strobe ends while chip select is still active
  p_strobe_before_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.strobeOn) |-> ctl.busy);
endmodule

// File: rtl/pbus_dpath.sv
module pbus_dpath
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic              colorMode,
  input  logic [1:0]        reqType,
  input  logic [DATA_W-1:0] reqData,
  output logic              busCsN,
  output logic              busRs,
  output logic              busRdPin,
  output logic              busWrPin,
  output logic [BUS_W-1:0]  busData
);
  localparam int COMP_LSB = BUS_W - COMP_W;

  logic             rsReg;
  logic [BUS_W-1:0] dataReg;
  logic [BUS_W-1:0] nextData;

  always_comb begin
    if (reqType == REQ_PIXEL && colorMode)
      nextData = {reqData[COMP_W-1:0], {COMP_LSB{1'b0}}};
    else
      nextData = {{(BUS_W-DATA_W){1'b0}}, reqData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsReg   <= 1'b0;
      dataReg <= '0;
    end else if (ctl.load) begin
      rsReg   <= (reqType != REQ_INDEX);
      dataReg <= nextData;
    end
  end

  assign busCsN   = !ctl.busy;
  assign busRs    = ctl.busy && rsReg;
  assign busData  = ctl.busy ? dataReg : '0;
  assign busRdPin = ctl.mode6800 ? ctl.strobeOn : 1'b1;
  assign busWrPin = ctl.mode6800 ? !ctl.busy : !ctl.strobeOn;

  // R6: data and register select stay put across a bus cycle
  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && $past(ctl.busy)) |-> ($stable(busData) && $stable(busRs)));

  // R7: a colour component on the top lines leaves the lower lines clear
  p_colour_low_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busData[BUS_W-1:COMP_LSB] != '0) |-> (busData[DATA_W-1:0] == '0));
endmodule

// File: rtl/pbus_writer.sv
module pbus_writer
  import pbus_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              colorMode,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgStrobe,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqType,
  input  logic [DATA_W-1:0] reqData,
  output logic              busCsN,
  output logic              busRs,
  output logic              busRdPin,
  output logic              busWrPin,
  output logic [BUS_W-1:0]  busData,
  output logic              ctrlRstN
);
  busCtl_t ctl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlRstN <= 1'b0;
    else       ctrlRstN <= 1'b1;
  end

  pbus_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .reqValid(reqValid),
    .reqType(reqType), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .cfgHold(cfgHold), .reqReady(reqReady), .ctl(ctl)
  );

  pbus_dpath #(.DATA_W(DATA_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .colorMode(colorMode),
    .reqType(reqType), .reqData(reqData), .busCsN(busCsN), .busRs(busRs),
    .busRdPin(busRdPin), .busWrPin(busWrPin), .busData(busData)
  );
endmodule

// File: tb/pbus_writer_test.sv
`timescale 1ns/1ps
module pbus_writer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0, colorMode = 1'b0;
  logic [3:0] cfgSetup = 4'd0, cfgStrobe = 4'd0, cfgHold = 4'd0;
  logic reqValid = 1'b0;
  logic [1:0] reqType = 2'd0;
  logic [7:0] reqData = 8'd0;
  logic reqReady, busCsN, busRs, busRdPin, busWrPin, ctrlRstN;
  logic [17:0] busData;

  int checks = 0, fails = 0, cycles = 0;
  bit running = 0, midSwitch = 0;

  // behavioural reference state
  bit mIdle = 1, mMode = 0, mColour = 0, mRst = 0;
  int mType = 0, mByte = 0, k = 0, total = 0, S = 0, W = 0, H = 0;

  always #5 clk = ~clk;

  pbus_writer uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .colorMode(colorMode),
    .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe), .cfgHold(cfgHold),
    .reqValid(reqValid), .reqReady(reqReady), .reqType(reqType),
    .reqData(reqData), .busCsN(busCsN), .busRs(busRs), .busRdPin(busRdPin),
    .busWrPin(busWrPin), .busData(busData), .ctrlRstN(ctrlRstN)
  );

  task automatic chk(input string tag, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, name, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mIdle = 1; mMode = 0; mRst = 0; k = 0;
    end else begin
      mRst = 1;
      if (mIdle) begin
        mMode = modeSel;
        if (reqValid && reqType != 2'd3) begin
          mType = reqType; mByte = reqData; mColour = colorMode;
          S = cfgSetup; W = cfgStrobe; H = cfgHold;
          total = S + W + H + 3; k = 0; mIdle = 0;
        end
      end else begin
        k++;
        if (k == total) mIdle = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      bit strobe;
      int expData, expRd, expWr;
      string pinTag;
      strobe = !mIdle && (k > S) && (k <= S + W + 1);
      pinTag = midSwitch ? "R8" : (mMode ? "R5" : "R4");
      if (mMode) begin expRd = strobe; expWr = mIdle; end
      else       begin expRd = 1;      expWr = !strobe; end
      if (mType == 2 && mColour) expData = (mByte & 63) << 12;
      else                       expData = mByte;
      chk("R1", "ctrlRstN", ctrlRstN, mRst);
      chk("R3", "reqReady", reqReady, mIdle);
      chk(pinTag, "busRdPin", busRdPin, expRd);
      chk(pinTag, "busWrPin", busWrPin, expWr);
      if (mIdle) begin
        chk("R9", "busCsN", busCsN, 1);
        chk("R9", "busRs", busRs, 0);
        chk("R9", "busData", busData, 0);
      end else begin
        chk((k > S + W + 1) ? "R10" : "R4", "busCsN", busCsN, 0);
        chk("R2", "busRs", busRs, mType != 0);
        chk((mType == 2 && mColour) ? "R7" : "R6", "busData", busData, expData);
      end
    end
  end

  task automatic send(input int t, input int d);
    bit rdy;
    reqValid = 1; reqType = t[1:0]; reqData = d[7:0];
    forever begin
      rdy = reqReady;
      @(negedge clk);
      if (rdy) break;
    end
    reqValid = 0;
  endtask

  task automatic waitIdle();
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setCfg(input int s, input int w, input int h);
    cfgSetup = s[3:0]; cfgStrobe = w[3:0]; cfgHold = h[3:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ctrlRstN in reset", ctrlRstN, 0);
    chk("R1", "busCsN in reset", busCsN, 1);
    chk("R1", "reqReady in reset", reqReady, 1);
    rstN = 1;
    running = 1;
    @(negedge clk);
    chk("R1", "ctrlRstN after release", ctrlRstN, 1);

    // strobe mode, command pair
    setCfg(1, 2, 1);
    send(0, 8'h2e); send(1, 8'h5a); waitIdle();
    setCfg(0, 0, 0);
    send(0, 8'h01); send(1, 8'hff); send(2, 8'h3c); waitIdle();

    // reserved request: accepted, no bus cycle
    send(3, 8'haa);
    chk("R2", "busCsN after reserved", busCsN, 1);
    chk("R2", "reqReady after reserved", reqReady, 1);
    @(negedge clk);
    chk("R2", "busCsN after reserved +1", busCsN, 1);

    // colour mode, one pixel as R,G,B
    colorMode = 1; setCfg(2, 1, 0);
    send(2, 8'hff); send(2, 8'h15); send(2, 8'h2a);
    send(1, 8'h77); waitIdle();

    // enable mode
    modeSel = 1; colorMode = 0; setCfg(1, 3, 2);
    @(negedge clk);
    send(0, 8'h09); send(1, 8'h03); waitIdle();
    colorMode = 1; setCfg(0, 0, 1);
    send(2, 8'h3f); send(0, 8'h81); waitIdle();

    // mid-cycle changes must not affect the running cycle
    modeSel = 0; colorMode = 0; setCfg(2, 2, 2);
    @(negedge clk);
    send(1, 8'hc3);
    midSwitch = 1; modeSel = 1; colorMode = 1; setCfg(0, 0, 0);
    while (!reqReady) @(negedge clk);
    midSwitch = 0;
    modeSel = 0; colorMode = 1; setCfg(3, 1, 3);
    send(2, 8'h2d);
    modeSel = 1; colorMode = 0; setCfg(0, 0, 0);
    midSwitch = 1;
    while (!reqReady) @(negedge clk);
    midSwitch = 0;
    repeat (3) @(negedge clk);

    running = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule